// File: doc/BRIEF.md
# Real-Time Clock Calendar Core

This block keeps wall-clock time and a calendar date in six counters: seconds, minutes, hours, day, month and a two-digit year. Host software reaches them through a byte-wide register port with separate read and write strobes. Four control registers sit beside the time registers. The first sets the divider mode and flags an update that is about to happen. The second gives the set-inhibit bit and the choices of number format and hour format. The third reads zero. The fourth reports that the stored time is valid.

A one-cycle `ref_tick` pulse comes from a 32.768 kHz reference. It drives a prescaler that issues one calendar update for every `TICKS_PER_SEC` pulses. For the last `UIP_TICKS` pulses before each update, an update-pending flag reads 1. The default of 80 pulses is about 2.44 ms. Software can wait for this flag to fall and then read a consistent snapshot of the time. To set the clock safely, software holds updates with the set-inhibit bit, or parks the divider in reset. It then writes the fields and releases the divider. The first update comes half a second after the release.

The counters are kept in binary inside the block. Each field is converted to BCD or binary, and the hour to 12-hour or 24-hour form, on every read and write.

Top module: `rtc_core`

## Requirements
- R1: A write to a time register (address 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year) takes effect on the next clock edge, whatever the divider or inhibit state. A read strobe returns the addressed register on `bus_rdata` one cycle later.
- R2: Control B bit 2 selects the data format: 0 means every time field is packed BCD (tens in bits 7:4), 1 means plain binary.
- R3: Control B bit 1 set selects 24-hour hours (0–23). Clear selects 12-hour hours (1–12) with bit 7 set for PM; hour 0 reads as 12 AM and hour 12 as 12 PM.
- R4: On an update, seconds wrap 59→0 with a carry into minutes, minutes wrap 59→0 with a carry into hours, and hours wrap 23→0 with a carry into the day.
- R5: The day wraps to 1 after the last day of its month: 30 for April, June, September and November; 29 for February when the year is a multiple of 4 and 28 otherwise; 31 for all other months.
- R6: The month wraps 12→1 with a carry into the year, and the year wraps 99→0.
- R7: Control A bit 7 reads 1 during the last `UIP_TICKS` reference pulses before an update and clears on the same edge that loads the new time.
- R8: While control B bit 7 is 1, no update changes the time registers and control A bit 7 reads 0.
- R9: Control A bits 6:4 set the divider. 3'b010 runs it. 3'b110 and 3'b111 hold the chain at its half-second point, so the first update comes `TICKS_PER_SEC/2` pulses after release. Any other value stops counting.
- R10: Control A bits 6:0 read back as written. Bit 7 is read-only.
- R11: Control D reads 0x80 and control C reads 0x00. Writes to either have no effect.
- R12: Reset gives 00:00:00 on day 1, month 1, year 0, control A 0x60 (divider held), control B 0x02 (BCD, 24-hour) and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| bus_addr | input | 4 | Register address (0–9) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
A write changes a register at the edge that samples its strobe. Read data appears one cycle after the read strobe, so every check drives a strobe at a falling edge and samples at the next falling edge. Reference pulses are driven only by the bench and are counted one at a time. Each check of the update flag and of the time is therefore placed at an exact pulse count from the divider release: the flag just before its window opens, inside the window, and after the pulse that makes the update. Between pulses the bench reads freely, because no state changes without a pulse.

// File: rtl/rtc_pkg.sv
// rtc_pkg: types, register addresses and format helpers shared by the
// clock core. Assumes time fields are held as 7-bit binary values.
package rtc_pkg;

    typedef enum logic [3:0] {
        REG_SEC  = 4'd0,
        REG_MIN  = 4'd1,
        REG_HOUR = 4'd2,
        REG_DAY  = 4'd3,
        REG_MON  = 4'd4,
        REG_YEAR = 4'd5,
        REG_CTLA = 4'd6,
        REG_CTLB = 4'd7,
        REG_CTLC = 4'd8,
        REG_CTLD = 4'd9
    } rtc_addr_e;

    typedef struct packed {
        logic [6:0] year;
        logic [6:0] mon;
        logic [6:0] day;
        logic [6:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    localparam logic [2:0] DIV_RUN = 3'b010;

    // Binary value to packed BCD.
    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // Packed BCD to binary value.
    function automatic logic [6:0] from_bcd(input logic [7:0] b);
        return 7'({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
    endfunction

    // Plain field to its port format.
    function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    // Port format to a plain field.
    function automatic logic [6:0] dec_field(input logic [7:0] b, input logic bin);
        return bin ? b[6:0] : from_bcd(b);
    endfunction

    // Hour 0..23 to port format, 12-hour form with PM in bit 7.
    function automatic logic [7:0] enc_hour(input logic [6:0] h, input logic bin,
                                            input logic h24);
        logic [6:0] h12;
        logic [7:0] f;
        if (h24) return enc_field(h, bin);
        h12 = (h == 7'd0) ? 7'd12 : ((h > 7'd12) ? h - 7'd12 : h);
        f   = enc_field(h12, bin);
        return {(h >= 7'd12), f[6:0]};
    endfunction

    // Port-format hour to 0..23.
    function automatic logic [6:0] dec_hour(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [6:0] v;
        if (h24) return dec_field(b, bin);
        v = dec_field({1'b0, b[6:0]}, bin);
        if (v == 7'd12) return b[7] ? 7'd12 : 7'd0;
        return b[7] ? v + 7'd12 : v;
    endfunction

    // Last day of a month; leap February in years divisible by 4.
    function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] year);
        case (mon)
            7'd2:                       return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
            default:                    return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// rtc_prescaler: counts reference pulses and issues a one-cycle update strobe
// once per TICKS_PER_SEC pulses. Assumes UIP_TICKS <= TICKS_PER_SEC/2.
// While hold is high the count parks at the half-second point.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic run,
    input  logic hold,
    input  logic inhibit,
    output logic upd,
    output logic uip
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF      = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] UIP_START = CW'(TICKS_PER_SEC - UIP_TICKS);

    logic [CW-1:0] cnt_q;

    // Advance the reference count, or park it at half while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            cnt_q <= HALF;
        else if (run && ref_tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Update on the pulse that wraps the count, unless inhibited.
    always_comb upd = run && ref_tick && (cnt_q == LAST) && !inhibit;

    // Pending flag covers the final window of the second.
    always_comb uip = run && !inhibit && (cnt_q >= UIP_START);

endmodule

// File: rtl/rtc_calendar.sv
// rtc_calendar: the six binary time counters with carry chain and a write
// port. Assumes at most one field written per cycle; a write overrides the
// update for that field only.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int VAL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    output rtc_time_t        cur
);
    rtc_time_t nxt;

    // Next time: carry chain on update, then any host write on top.
    always_comb begin
        nxt = cur;
        if (upd) begin
            if (cur.sec >= 7'd59) begin
                nxt.sec = '0;
                if (cur.min >= 7'd59) begin
                    nxt.min = '0;
                    if (cur.hour >= 7'd23) begin
                        nxt.hour = '0;
                        if (cur.day >= month_len(cur.mon, cur.year)) begin
                            nxt.day = 7'd1;
                            if (cur.mon >= 7'd12) begin
                                nxt.mon  = 7'd1;
                                nxt.year = (cur.year >= 7'd99) ? '0 : cur.year + 7'd1;
                            end else begin
                                nxt.mon = cur.mon + 7'd1;
                            end
                        end else begin
                            nxt.day = cur.day + 7'd1;
                        end
                    end else begin
                        nxt.hour = cur.hour + 7'd1;
                    end
                end else begin
                    nxt.min = cur.min + 7'd1;
                end
            end else begin
                nxt.sec = cur.sec + 7'd1;
            end
        end
        if (wr_en) begin
            case (wr_idx)
                3'd0:    nxt.sec  = wr_val;
                3'd1:    nxt.min  = wr_val;
                3'd2:    nxt.hour = wr_val;
                3'd3:    nxt.day  = wr_val;
                3'd4:    nxt.mon  = wr_val;
                3'd5:    nxt.year = wr_val;
                default: ;
            endcase
        end
    end

    // Hold the time; reset to midnight of day 1, month 1, year 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '{year: 7'd0, mon: 7'd1, day: 7'd1, hour: 7'd0, min: 7'd0, sec: 7'd0};
        else
            cur <= nxt;
    end

endmodule

// File: rtl/rtc_core.sv
// rtc_core: register port, control registers and format conversion around
// the prescaler and calendar. Assumes one strobe per cycle from the host.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 80,
    parameter int ADDR_W        = 4,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [DATA_W-2:0] CTLA_RST = 7'h60;
    localparam logic [DATA_W-1:0] CTLB_RST = 8'h02;
    localparam logic [DATA_W-1:0] CTLD_VAL = 8'h80;

    logic [DATA_W-2:0] ctl_a_q;
    logic [DATA_W-1:0] ctl_b_q;
    logic              run, hold, set_bit, bin_mode, h24;
    logic              upd, uip;
    logic              time_wr;
    logic [6:0]        wr_val;
    logic [DATA_W-1:0] rd_mux;
    rtc_time_t         cur;

    // Decode control fields.
    always_comb begin
        run      = (ctl_a_q[6:4] == DIV_RUN);
        hold     = &ctl_a_q[6:5];
        set_bit  = ctl_b_q[7];
        bin_mode = ctl_b_q[2];
        h24      = ctl_b_q[1];
    end

    // Convert host write data for the time registers.
    always_comb begin
        time_wr = bus_wr && (bus_addr <= ADDR_W'(REG_YEAR));
        wr_val  = (bus_addr == ADDR_W'(REG_HOUR)) ? dec_hour(bus_wdata, bin_mode, h24)
                                                  : dec_field(bus_wdata, bin_mode);
    end

    // Control register writes; control C and D are not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_a_q <= CTLA_RST;
            ctl_b_q <= CTLB_RST;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(REG_CTLA)) ctl_a_q <= bus_wdata[DATA_W-2:0];
            if (bus_addr == ADDR_W'(REG_CTLB)) ctl_b_q <= bus_wdata;
        end
    end

    rtc_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_TICKS    (UIP_TICKS)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .run     (run),
        .hold    (hold),
        .inhibit (set_bit),
        .upd     (upd),
        .uip     (uip)
    );

    rtc_calendar u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .wr_en (time_wr),
        .wr_idx(bus_addr[2:0]),
        .wr_val(wr_val),
        .cur   (cur)
    );

    // Select the addressed register in port format.
    always_comb begin
        case (bus_addr)
            ADDR_W'(REG_SEC):  rd_mux = enc_field(cur.sec, bin_mode);
            ADDR_W'(REG_MIN):  rd_mux = enc_field(cur.min, bin_mode);
            ADDR_W'(REG_HOUR): rd_mux = enc_hour(cur.hour, bin_mode, h24);
            ADDR_W'(REG_DAY):  rd_mux = enc_field(cur.day, bin_mode);
            ADDR_W'(REG_MON):  rd_mux = enc_field(cur.mon, bin_mode);
            ADDR_W'(REG_YEAR): rd_mux = enc_field(cur.year, bin_mode);
            ADDR_W'(REG_CTLA): rd_mux = {uip, ctl_a_q};
            ADDR_W'(REG_CTLB): rd_mux = ctl_b_q;
            ADDR_W'(REG_CTLD): rd_mux = CTLD_VAL;
            default:           rd_mux = '0;
        endcase
    end

    // Register read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/rtc_core_chk.sv
// rtc_core_chk: temporal properties of the clock core, bound into rtc_core.
module rtc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       uip,
    input logic       upd,
    input logic       hold,
    input logic       set_bit,
    input logic [6:0] sec
);
    // R7: an update only happens inside the pending window
    p_upd_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> uip);

    // R7: the pending flag clears with the update
    p_uip_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !uip);

    // R8: inhibit keeps the flag low
    p_uip_low_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_bit |-> !uip);

    // R8: inhibit with no host write leaves seconds unchanged
    p_set_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bit && !bus_wr) |=> $stable(sec));

    // R9: a held divider never updates
    p_hold_no_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !upd);

    // R10: control A bit 7 reads the pending flag
    p_flag_readout_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'd6) |=> (bus_rdata[7] == $past(uip)));

endmodule

bind rtc_core rtc_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .uip      (uip),
    .upd      (upd),
    .hold     (hold),
    .set_bit  (set_bit),
    .sec      (cur.sec)
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 64;
    localparam int UIPT       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    int e_sec, e_min, e_hour, e_day, e_mon, e_year;
    bit m_bin, m_h24;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_core #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] benc(int v, bit bin);
        return bin ? 8'(v) : 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [7:0] benc_hour(int h, bit bin, bit h24);
        int h12;
        if (h24) return benc(h, bin);
        h12 = (h == 0) ? 12 : ((h > 12) ? h - 12 : h);
        return benc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    function automatic int mdays(int mon, int year);
        if (mon == 2) return (year % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic advance();
        e_sec++;
        if (e_sec == 60) begin
            e_sec = 0; e_min++;
            if (e_min == 60) begin
                e_min = 0; e_hour++;
                if (e_hour == 24) begin
                    e_hour = 0; e_day++;
                    if (e_day > mdays(e_mon, e_year)) begin
                        e_day = 1; e_mon++;
                        if (e_mon == 13) begin
                            e_mon = 1; e_year = (e_year + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rdchk(string tag, logic [3:0] a, logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic check_time(string tag);
        rdchk({tag, " sec"},  4'd0, benc(e_sec, m_bin));
        rdchk({tag, " min"},  4'd1, benc(e_min, m_bin));
        rdchk({tag, " hour"}, 4'd2, benc_hour(e_hour, m_bin, m_h24));
        rdchk({tag, " day"},  4'd3, benc(e_day, m_bin));
        rdchk({tag, " mon"},  4'd4, benc(e_mon, m_bin));
        rdchk({tag, " year"}, 4'd5, benc(e_year, m_bin));
    endtask

    function automatic logic [7:0] ctlb(bit set, bit bin, bit h24);
        return {set, 4'b0000, bin, h24, 1'b0};
    endfunction

    // Hold divider, write time under inhibit, release inhibit (divider stays held).
    task automatic load(int s, int mi, int h, int d, int mo, int y, bit bin, bit h24);
        e_sec = s; e_min = mi; e_hour = h; e_day = d; e_mon = mo; e_year = y;
        m_bin = bin; m_h24 = h24;
        wr(4'd6, 8'h60);
        wr(4'd7, ctlb(1'b1, bin, h24));
        wr(4'd0, benc(s, bin));
        wr(4'd1, benc(mi, bin));
        wr(4'd2, benc_hour(h, bin, h24));
        wr(4'd3, benc(d, bin));
        wr(4'd4, benc(mo, bin));
        wr(4'd5, benc(y, bin));
        wr(4'd7, ctlb(1'b0, bin, h24));
    endtask

    // Load, release, and check the first update half a second later.
    task automatic run_case(string tag, int s, int mi, int h, int d, int mo, int y,
                            bit bin, bit h24);
        load(s, mi, h, d, mo, y, bin, h24);
        check_time({tag, " R1 load"});
        wr(4'd6, 8'h20);
        ticks(TPS / 2);
        advance();
        check_time(tag);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        rdchk("R12 sec",  4'd0, 8'h00);
        rdchk("R12 min",  4'd1, 8'h00);
        rdchk("R12 hour", 4'd2, 8'h00);
        rdchk("R12 day",  4'd3, 8'h01);
        rdchk("R12 mon",  4'd4, 8'h01);
        rdchk("R12 year", 4'd5, 8'h00);
        rdchk("R12 ctla", 4'd6, 8'h60);
        rdchk("R12 ctlb", 4'd7, 8'h02);

        // R11: C and D fixed, writes ignored
        wr(4'd9, 8'h00);
        rdchk("R11 ctld", 4'd9, 8'h80);
        wr(4'd8, 8'hFF);
        rdchk("R11 ctlc", 4'd8, 8'h00);

        // R10: bit 7 of A read-only
        wr(4'd6, 8'hE5);
        rdchk("R10 ctla", 4'd6, 8'h65);

        // R6 R7 R9: year-end rollover in BCD 24-hour, pulse-exact timing
        load(59, 59, 23, 31, 12, 99, 1'b0, 1'b1);
        wr(4'd6, 8'h20);
        ticks(TPS / 2 - UIPT - 1);
        rdchk("R7 before window", 4'd6, 8'h20);
        ticks(1);
        rdchk("R7 window open", 4'd6, 8'hA0);
        ticks(UIPT - 1);
        rdchk("R9 no update before half second", 4'd0, 8'h59);
        rdchk("R7 window last pulse", 4'd6, 8'hA0);
        ticks(1);
        advance();
        check_time("R6 year wrap");
        rdchk("R7 flag cleared", 4'd6, 8'h20);

        // R8: inhibit freezes time and masks the flag
        wr(4'd7, ctlb(1'b1, 1'b0, 1'b1));
        ticks(TPS - 1);
        rdchk("R8 flag masked", 4'd6, 8'h20);
        ticks(1);
        check_time("R8 frozen");
        wr(4'd7, ctlb(1'b0, 1'b0, 1'b1));
        ticks(TPS);
        advance();
        check_time("R8 resumed");

        // R9: held and stopped divider
        wr(4'd6, 8'h60);
        ticks(2 * TPS);
        check_time("R9 held");
        wr(4'd6, 8'h00);
        ticks(2 * TPS);
        check_time("R9 stopped");

        // R5: month lengths and leap years, binary mode
        run_case("R5 leap feb28", 59, 59, 23, 28, 2, 4, 1'b1, 1'b1);
        run_case("R5 plain feb28", 59, 59, 23, 28, 2, 3, 1'b1, 1'b1);
        run_case("R5 feb29", 59, 59, 23, 29, 2, 8, 1'b1, 1'b1);
        run_case("R5 apr30", 59, 59, 23, 30, 4, 21, 1'b0, 1'b1);
        run_case("R5 jan31", 59, 59, 23, 31, 1, 50, 1'b1, 1'b1);

        // R3: 12-hour form
        run_case("R3 to noon", 59, 59, 11, 5, 6, 7, 1'b0, 1'b0);
        run_case("R3 to 1pm", 59, 59, 12, 5, 6, 7, 1'b0, 1'b0);
        run_case("R3 to midnight", 59, 59, 23, 5, 6, 7, 1'b1, 1'b0);

        // R2: binary mode read of a carry
        run_case("R2 binary", 59, 9, 14, 9, 9, 9, 1'b1, 1'b1);

        // R1: write while running takes effect at once
        wr(4'd1, benc(17, m_bin));
        e_min = 17;
        rdchk("R1 live write", 4'd1, benc(17, m_bin));

        // R4: random times biased toward carries, all modes
        for (int k = 0; k < 24; k++) begin
            int s, mi, h, mo, y, dd;
            bit b, h24;
            b   = 1'($urandom % 2);
            h24 = 1'($urandom % 2);
            s   = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            mi  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            h   = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            mo  = 1 + int'($urandom % 12);
            y   = int'($urandom % 100);
            dd  = ($urandom % 2 == 0) ? mdays(mo, y) : 1 + int'($urandom % mdays(mo, y));
            run_case("R4 random", s, mi, h, dd, mo, y, b, h24);
            ticks(TPS);
            advance();
            check_time("R4 random next");
        end

        rd(4'd8, d);
        chk("R11 ctlc final", d, 8'h00);
        finish_up();
    end
endmodule